// File: doc/BRIEF.md
# Multiplexed-Address DRAM Read Sequencer

This block reads and writes single bytes ("supercells") of a small dynamic memory array that it models internally. The array is a square grid of `2**ADDR_W` rows by `2**ADDR_W` columns of `DATA_W`-bit cells. With the defaults that is 4 by 4 cells of 8 bits. One narrow address bus carries the row index and then the column index in two strobed phases. The row phase copies the whole selected row into a row buffer. The column phase picks one cell out of that buffer, or overwrites one cell in it.

A client offers a request with a row, a column and an optional write byte. The request is taken only when `req_ready` is high. From the row strobe onward, the block runs a fixed sequence:

1. Row strobe.
2. `WAIT_CYC` idle cycles.
3. Column strobe.
4. A closing cycle in which the row buffer is written back. For a read, `rsp_valid` pulses in this cycle with the byte.

A free-running interval counter raises a refresh request every `REF_INTERVAL` cycles. The refresh request wins over a new client request but never cuts into one already running. Each refresh opens one row, chosen in turn, and writes it back unchanged.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `row_strobe`, `col_strobe` and `refresh_active` are low, `req_ready` is high, and every cell reads back as zero.
- R2: A request is taken only on a clock edge where `req_ready` is high, and `req_ready` is never high while `busy` is high. A `req_valid` offered at any other time has no effect: it starts no strobe and changes no stored cell.
- R3: One cycle after a request is taken, `row_strobe` is high for one cycle with `addr_bus` equal to the row index. Later, `col_strobe` is high for one cycle with `addr_bus` equal to the column index. The two strobes are never high together.
- R4: Exactly `WAIT_CYC` cycles lie between the row strobe cycle and the column strobe cycle.
- R5: For a read (`req_write` = 0), `rsp_valid` is a one-cycle pulse in the cycle right after the column strobe. In that cycle `rsp_data` equals the byte stored at the requested row and column.
- R6: `busy` is high in every cycle from the row strobe through the cycle that follows the column strobe, which is the `rsp_valid` cycle for a read. `busy` also stays high across a refresh.
- R7: A write (`req_write` = 1) runs the same strobe sequence, produces no `rsp_valid`, and stores `req_wdata` in the addressed cell. The other cells of that row are unchanged.
- R8: In an otherwise idle block, refresh row strobes are exactly `REF_INTERVAL` cycles apart. While a refresh is due, `req_ready` is low, and the refresh row strobe follows in the next cycle. A refresh never falls inside a running request's sequence.
- R9: A refresh drives `row_strobe` with `refresh_active` high and `addr_bus` set to the refreshed row. It never drives `col_strobe`. Rows are visited in the order 0, 1, 2, … wrapping to 0. Refresh leaves all stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ADDR_W | Row index of the request |
| req_col | input | ADDR_W | Column index of the request |
| req_wdata | input | DATA_W | Byte to store on a write |
| req_ready | output | 1 | A request offered now will be taken |
| busy | output | 1 | Sequence or refresh in progress |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | DATA_W | Byte read back |
| addr_bus | output | ADDR_W | Shared row/column address bus |
| row_strobe | output | 1 | Row strobe, active high |
| col_strobe | output | 1 | Column strobe, active high |
| refresh_active | output | 1 | Current row cycle is a refresh |

## Verification
The bench builds the block with `WAIT_CYC` = 3 and `REF_INTERVAL` = 40. The nonzero wait exercises the counted gap between the strobes and the address switch from row to column on the bus. The short refresh interval means refreshes fall due many times during the access traffic. This drives the cases where a refresh is due at the same moment as a request, and where it lands just after a sequence ends. It also walks the round-robin row pointer through several full wraps within a short run.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ACT     = 3'd1,
      ST_WAIT    = 3'd2,
      ST_CAS     = 3'd3,
      ST_CLOSE   = 3'd4,
      ST_REF_ACT = 3'd5,
      ST_REF_WB  = 3'd6
   } seq_state_t;

endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             rd_row,
   output logic [(1<<ADDR_W)*DATA_W-1:0] rd_data,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_row,
   input  logic [(1<<ADDR_W)*DATA_W-1:0] wr_data
);

   localparam int NROWS    = 1 << ADDR_W;
   localparam int ROW_BITS = NROWS * DATA_W;

   logic [ROW_BITS-1:0] rows [NROWS];

   for (genvar r = 0; r < NROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rows[r] <= '0;
         end else if (wr_en && (wr_row == ADDR_W'(r))) begin
            rows[r] <= wr_data;
         end
      end
   end

   assign rd_data = rows[rd_row];

endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_en,
   input  logic [(1<<ADDR_W)*DATA_W-1:0] load_data,
   input  logic                          col_wr_en,
   input  logic [ADDR_W-1:0]             col_sel,
   input  logic [DATA_W-1:0]             col_wdata,
   output logic [(1<<ADDR_W)*DATA_W-1:0] buf_q,
   output logic [DATA_W-1:0]             col_rdata
);

   localparam int NCOLS = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [NCOLS];

   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cells[c] <= '0;
         end else if (load_en) begin
            cells[c] <= load_data[c*DATA_W +: DATA_W];
         end else if (col_wr_en && (col_sel == ADDR_W'(c))) begin
            cells[c] <= col_wdata;
         end
      end
      assign buf_q[c*DATA_W +: DATA_W] = cells[c];
   end

   assign col_rdata = cells[col_sel];

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int ADDR_W       = 2,
   parameter int REF_INTERVAL = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_done,
   output logic              ref_pending,
   output logic [ADDR_W-1:0] ref_row
);

   localparam int CNT_W = $clog2(REF_INTERVAL);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_INTERVAL - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         ref_pending <= 1'b0;
      end else begin
         if (cnt_q == CNT_LAST) begin
            cnt_q       <= '0;
            ref_pending <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (ref_done) begin
               ref_pending <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_row <= '0;
      end else if (ref_done) begin
         ref_row <= ref_row + 1'b1;
      end
   end

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 8,
   parameter int WAIT_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_row,
   input  logic [ADDR_W-1:0] req_col,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ref_pending,
   input  logic [ADDR_W-1:0] ref_row,
   input  logic [DATA_W-1:0] col_rdata,
   output logic              req_ready,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] addr_bus,
   output logic              row_strobe,
   output logic              col_strobe,
   output logic              refresh_active,
   output logic              buf_load,
   output logic [ADDR_W-1:0] buf_load_row,
   output logic              col_wr_en,
   output logic [ADDR_W-1:0] col_sel,
   output logic [DATA_W-1:0] col_wdata,
   output logic              arr_wr_en,
   output logic [ADDR_W-1:0] arr_wr_row,
   output logic              ref_done
);

   seq_state_t        state_q, state_d;
   logic [ADDR_W-1:0] lat_row, lat_col;
   logic [DATA_W-1:0] lat_wdata;
   logic              lat_wr;
   logic              accept;
   logic              wait_done;

   assign accept = (state_q == ST_IDLE) && !ref_pending && req_valid;

   if (WAIT_CYC > 0) begin : g_wait_cnt
      localparam int WC_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
      logic [WC_W-1:0] wcnt;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wcnt <= '0;
         end else if (state_q == ST_ACT) begin
            wcnt <= '0;
         end else if (state_q == ST_WAIT) begin
            wcnt <= wcnt + 1'b1;
         end
      end
      assign wait_done = (wcnt == WC_W'(WAIT_CYC - 1));
   end else begin : g_no_wait
      assign wait_done = 1'b1;
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (ref_pending)    state_d = ST_REF_ACT;
            else if (req_valid) state_d = ST_ACT;
         end
         ST_ACT:     state_d = (WAIT_CYC == 0) ? ST_CAS : ST_WAIT;
         ST_WAIT:    if (wait_done) state_d = ST_CAS;
         ST_CAS:     state_d = ST_CLOSE;
         ST_CLOSE:   state_d = ST_IDLE;
         ST_REF_ACT: state_d = ST_REF_WB;
         ST_REF_WB:  state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_row   <= '0;
         lat_col   <= '0;
         lat_wdata <= '0;
         lat_wr    <= 1'b0;
      end else if (accept) begin
         lat_row   <= req_row;
         lat_col   <= req_col;
         lat_wdata <= req_wdata;
         lat_wr    <= req_write;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= (state_q == ST_CAS) && !lat_wr;
         if ((state_q == ST_CAS) && !lat_wr) begin
            rsp_data <= col_rdata;
         end
      end
   end

   always_comb begin
      addr_bus = '0;
      case (state_q)
         ST_ACT, ST_WAIT:       addr_bus = lat_row;
         ST_CAS:                addr_bus = lat_col;
         ST_REF_ACT, ST_REF_WB: addr_bus = ref_row;
         default:               addr_bus = '0;
      endcase
   end

   assign row_strobe     = (state_q == ST_ACT) || (state_q == ST_REF_ACT);
   assign col_strobe     = (state_q == ST_CAS);
   assign refresh_active = (state_q == ST_REF_ACT) || (state_q == ST_REF_WB);
   assign busy           = (state_q != ST_IDLE);
   assign req_ready      = (state_q == ST_IDLE) && !ref_pending;

   assign buf_load     = row_strobe;
   assign buf_load_row = (state_q == ST_REF_ACT) ? ref_row : lat_row;
   assign col_wr_en    = (state_q == ST_CAS) && lat_wr;
   assign col_sel      = lat_col;
   assign col_wdata    = lat_wdata;
   assign arr_wr_en    = (state_q == ST_CLOSE) || (state_q == ST_REF_WB);
   assign arr_wr_row   = (state_q == ST_REF_WB) ? ref_row : lat_row;
   assign ref_done     = (state_q == ST_REF_WB);

endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq #(
   parameter int ADDR_W       = 2,
   parameter int DATA_W       = 8,
   parameter int WAIT_CYC     = 2,
   parameter int REF_INTERVAL = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_row,
   input  logic [ADDR_W-1:0] req_col,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] addr_bus,
   output logic              row_strobe,
   output logic              col_strobe,
   output logic              refresh_active
);

   localparam int NCOLS    = 1 << ADDR_W;
   localparam int ROW_BITS = NCOLS * DATA_W;

   if (ADDR_W < 1 || ADDR_W > 4) begin : g_bad_addr_w
      $error("dram_rd_seq: ADDR_W must lie in 1..4");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dram_rd_seq: DATA_W must be positive");
   end
   if (WAIT_CYC < 0 || WAIT_CYC > 64) begin : g_bad_wait
      $error("dram_rd_seq: WAIT_CYC must lie in 0..64");
   end
   if (REF_INTERVAL < WAIT_CYC + 16) begin : g_bad_ref
      $error("dram_rd_seq: REF_INTERVAL too short for one access plus a refresh");
   end

   logic                ref_pending, ref_done;
   logic [ADDR_W-1:0]   ref_row;
   logic                buf_load, col_wr_en, arr_wr_en;
   logic [ADDR_W-1:0]   buf_load_row, col_sel, arr_wr_row;
   logic [DATA_W-1:0]   col_wdata, col_rdata;
   logic [ROW_BITS-1:0] arr_rd_data, buf_q;

   dram_seq_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .WAIT_CYC (WAIT_CYC)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_write      (req_write),
      .req_row        (req_row),
      .req_col        (req_col),
      .req_wdata      (req_wdata),
      .ref_pending    (ref_pending),
      .ref_row        (ref_row),
      .col_rdata      (col_rdata),
      .req_ready      (req_ready),
      .busy           (busy),
      .rsp_valid      (rsp_valid),
      .rsp_data       (rsp_data),
      .addr_bus       (addr_bus),
      .row_strobe     (row_strobe),
      .col_strobe     (col_strobe),
      .refresh_active (refresh_active),
      .buf_load       (buf_load),
      .buf_load_row   (buf_load_row),
      .col_wr_en      (col_wr_en),
      .col_sel        (col_sel),
      .col_wdata      (col_wdata),
      .arr_wr_en      (arr_wr_en),
      .arr_wr_row     (arr_wr_row),
      .ref_done       (ref_done)
   );

   dram_cell_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_row  (buf_load_row),
      .rd_data (arr_rd_data),
      .wr_en   (arr_wr_en),
      .wr_row  (arr_wr_row),
      .wr_data (buf_q)
   );

   dram_row_buffer #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (buf_load),
      .load_data (arr_rd_data),
      .col_wr_en (col_wr_en),
      .col_sel   (col_sel),
      .col_wdata (col_wdata),
      .buf_q     (buf_q),
      .col_rdata (col_rdata)
   );

   dram_refresh_timer #(
      .ADDR_W       (ADDR_W),
      .REF_INTERVAL (REF_INTERVAL)
   ) u_ref (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_done    (ref_done),
      .ref_pending (ref_pending),
      .ref_row     (ref_row)
   );

endmodule

// File: rtl/dram_seq_checks.sv
module dram_seq_checks #(
   parameter int ADDR_W   = 2,
   parameter int WAIT_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              busy,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] addr_bus,
   input logic              row_strobe,
   input logic              col_strobe,
   input logic              refresh_active
);

   localparam int GAP_W = $clog2(WAIT_CYC + 2) + 1;
   localparam logic [GAP_W-1:0] GAP_MAX = '1;

   logic [GAP_W-1:0]  gap;
   logic [ADDR_W-1:0] exp_ref;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap <= GAP_MAX;
      end else if (row_strobe) begin
         gap <= '0;
      end else if (gap != GAP_MAX) begin
         gap <= gap + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_ref <= '0;
      end else if (row_strobe && refresh_active) begin
         exp_ref <= exp_ref + 1'b1;
      end
   end

   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy);                                                   // R2
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(row_strobe && col_strobe));                                           // R3
   AST_RAS_CAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      col_strobe |-> (gap == GAP_W'(WAIT_CYC)));                              // R4
   AST_VALID_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(col_strobe));                                       // R5
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);                                              // R5
   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (row_strobe || col_strobe || rsp_valid) |-> busy);                      // R6
   AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_active |-> !col_strobe);                                        // R9
   AST_REF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (row_strobe && refresh_active) |-> (addr_bus == exp_ref));              // R9

endmodule

bind dram_rd_seq dram_seq_checks #(
   .ADDR_W   (ADDR_W),
   .WAIT_CYC (WAIT_CYC)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_ready      (req_ready),
   .busy           (busy),
   .rsp_valid      (rsp_valid),
   .addr_bus       (addr_bus),
   .row_strobe     (row_strobe),
   .col_strobe     (col_strobe),
   .refresh_active (refresh_active)
);

// File: tb/sim_dram_rd_seq.sv
`timescale 1ns/1ps
module sim_dram_rd_seq;

   localparam int ADDR_W       = 2;
   localparam int DATA_W       = 8;
   localparam int WAIT_CYC     = 3;
   localparam int REF_INTERVAL = 40;
   localparam int NCELL        = 1 << (2 * ADDR_W);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_row = '0;
   logic [ADDR_W-1:0] req_col = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              req_ready, busy, rsp_valid;
   logic [DATA_W-1:0] rsp_data;
   logic [ADDR_W-1:0] addr_bus;
   logic              row_strobe, col_strobe, refresh_active;

   int n_vec = 0;
   int n_bad = 0;
   int n_taken = 0;
   int n_client_rs = 0;
   int n_refresh = 0;
   bit done = 1'b0;
   logic [ADDR_W-1:0] exp_ref = '0;
   logic [DATA_W-1:0] mdl [NCELL];
   logic [DATA_W-1:0] exp_q [$];

   always #2.5 clk = ~clk;

   dram_rd_seq #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .WAIT_CYC     (WAIT_CYC),
      .REF_INTERVAL (REF_INTERVAL)
   ) u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_write      (req_write),
      .req_row        (req_row),
      .req_col        (req_col),
      .req_wdata      (req_wdata),
      .req_ready      (req_ready),
      .busy           (busy),
      .rsp_valid      (rsp_valid),
      .rsp_data       (rsp_data),
      .addr_bus       (addr_bus),
      .row_strobe     (row_strobe),
      .col_strobe     (col_strobe),
      .refresh_active (refresh_active)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // monitor: pops the scoreboard on every read response, follows refreshes
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected response", int'(rsp_data), 0);
            end else begin
               logic [DATA_W-1:0] e;
               e = exp_q.pop_front();
               chk(rsp_data == e, "R5 read data", int'(rsp_data), int'(e));
            end
         end
         if (row_strobe && refresh_active) begin
            chk(addr_bus == exp_ref, "R9 refresh row order", int'(addr_bus), int'(exp_ref));
            chk(!col_strobe, "R9 refresh without column strobe", int'(col_strobe), 0);
            exp_ref = exp_ref + 1'b1;
            n_refresh++;
         end
         if (row_strobe && !refresh_active) n_client_rs++;
      end
   end

   // driver: one access, with strict timing checks; optional stray request while busy
   task automatic access(input bit wr, input int row, input int col,
                         input logic [DATA_W-1:0] data, input bit intrude);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_row   = ADDR_W'(row);
      req_col   = ADDR_W'(col);
      req_wdata = data;
      n_taken++;
      if (wr) mdl[row*4+col] = data;
      else    exp_q.push_back(mdl[row*4+col]);
      @(negedge clk);
      req_valid = 1'b0;
      chk(row_strobe && !refresh_active, "R3 row strobe after take", int'(row_strobe), 1);
      chk(addr_bus == ADDR_W'(row), "R3 row on address bus", int'(addr_bus), row);
      chk(busy, "R6 busy at row strobe", int'(busy), 1);
      for (int w = 0; w < WAIT_CYC; w++) begin
         if (intrude && w == 0) begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_row   = ADDR_W'(row) ^ 2'b11;
            req_col   = ADDR_W'(col);
            req_wdata = 8'hEE;
         end
         @(negedge clk);
         req_valid = 1'b0;
         chk(!col_strobe && !row_strobe, "R4 no strobe in wait gap", int'(col_strobe), 0);
         chk(busy && !req_ready, "R2 R6 busy in wait gap", int'(busy), 1);
      end
      @(negedge clk);
      chk(col_strobe && !row_strobe, "R4 column strobe timing", int'(col_strobe), 1);
      chk(addr_bus == ADDR_W'(col), "R3 column on address bus", int'(addr_bus), col);
      @(negedge clk);
      chk(rsp_valid == !wr, "R5 R7 response only for reads", int'(rsp_valid), int'(!wr));
      chk(busy, "R6 busy through closing cycle", int'(busy), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         finish_run();
      end
   end

   initial begin
      int gap;
      for (int i = 0; i < NCELL; i++) mdl[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !rsp_valid, "R1 reset busy/valid low", int'(busy), 0);
      chk(!row_strobe && !col_strobe && !refresh_active, "R1 reset strobes low", int'(row_strobe), 0);
      chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
      // R1 cleared contents
      access(1'b0, 1, 2, '0, 1'b0);
      access(1'b0, 3, 3, '0, 1'b0);
      // R7 fill every cell in a scrambled order
      for (int i = 0; i < NCELL; i++) begin
         int k;
         k = (i * 7 + 3) % NCELL;
         access(1'b1, k / 4, k % 4, 8'(k * 16 + 5) ^ 8'hA5, 1'b0);
      end
      // R5 read back all in reverse
      for (int k = NCELL - 1; k >= 0; k--) access(1'b0, k / 4, k % 4, '0, 1'b0);
      // R7 overwrite one cell, neighbours in the same row unchanged
      access(1'b1, 2, 3, 8'h3C, 1'b0);
      for (int c = 0; c < 4; c++) access(1'b0, 2, c, '0, 1'b0);
      // R2 stray write offered while busy must be ignored
      access(1'b0, 3, 1, '0, 1'b1);
      access(1'b0, 0, 1, '0, 1'b0);
      // R8 refresh due: ready low, offered request ignored, refresh row strobe next
      @(negedge clk);
      while (!(!busy && !req_ready)) @(negedge clk);
      chk(!req_ready, "R8 ready low while refresh due", int'(req_ready), 0);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_row   = '0;
      req_col   = '0;
      req_wdata = 8'h5A;
      @(negedge clk);
      req_valid = 1'b0;
      chk(row_strobe && refresh_active, "R8 refresh wins over request", int'(refresh_active), 1);
      // R8 idle refresh spacing
      while (!(row_strobe && refresh_active)) @(negedge clk);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!(row_strobe && refresh_active));
      chk(gap == REF_INTERVAL, "R8 idle refresh spacing", gap, REF_INTERVAL);
      repeat (5 * REF_INTERVAL) @(negedge clk);
      // R9 contents survive refreshes; R2 cell 0,0 untouched by ignored write
      for (int k = 0; k < NCELL; k++) access(1'b0, k / 4, k % 4, '0, 1'b0);
      // back-to-back same row
      access(1'b0, 1, 0, '0, 1'b0);
      access(1'b0, 1, 3, '0, 1'b0);
      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R5 every read answered", exp_q.size(), 0);
      chk(n_client_rs == n_taken, "R2 client row strobes equal taken requests", n_client_rs, n_taken);
      chk(n_refresh >= 8, "R9 refresh rows walked", n_refresh, 8);
      done = 1'b1;
      finish_run();
   end

endmodule